// File: doc/BRIEF.md
# Shared-Port Synchronous FIFO Controller

This block is a single-clock first-in first-out buffer built on one single-port memory. A write pointer and a read pointer both address that memory through one address multiplexer, and the read request input is the multiplexer select. Because the port is shared, each cycle carries either a read or a write, never both. A read request always takes the port, and any write requested in the same cycle is dropped. A write finishes in one cycle because the write pointer always holds the next free slot. Read data comes straight from the memory through the address multiplexer, with no output register.

An occupancy counter from 0 to the depth drives the empty and full flags. It also blocks writes when the buffer is full and reads when it is empty. When no read is requested, the data output shows whatever word the write pointer addresses. The contract treats that value as undefined. When the buffer is full, the write pointer has wrapped onto the oldest entry, so the output then shows the word the next read will return.

Top module: `sp_fifo_top`

## Requirements
- R1: While reset is high at a clock edge, the next state has empty high and full low. Both pointers and the occupancy return to zero.
- R2: With read request low and the buffer not full, a write request stores the data word and increments the occupancy by one. Empty goes low at the clock edge that performs the first write.
- R3: With read request low and the buffer full, a write request changes neither the memory contents nor the occupancy, and full stays high.
- R4: While full with read request low, the data output equals the oldest stored entry.
- R5: With read request high and the buffer not empty, the data output shows the oldest entry in that same cycle. The read pointer advances at the next edge, and entries leave in write order, including across pointer wrap-around.
- R6: A write request in a cycle with read request high is discarded. Its data never appears in later reads.
- R7: A read request while empty leaves the read pointer and the occupancy unchanged, and empty stays high.
- R8: Empty is high exactly when the occupancy is 0 and full is high exactly when it equals DEPTH. The two are never high together.
- R9: Reset does not clear the memory. Right after reset, with read request low, the output shows the word last written to location 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| wrEn | input | 1 | Write request |
| wrData | input | DATA_W | Word to store |
| rdEn | input | 1 | Read request; also the memory address select |
| rdData | output | DATA_W | Memory word under the selected pointer |
| full | output | 1 | Occupancy equals DEPTH |
| empty | output | 1 | Occupancy is zero |

## Verification
The directed patterns each separate one outcome from its neighbours:
- Reads on an empty buffer test that the read pointer is guarded.
- Writes continuing past full show whether the guard or the wrapped pointer wins.
- A read and a write requested together expose any write that sneaks through the shared port.
- A reset that follows a full load tells an untouched memory apart from a cleared one.

Random mixes of read, write and idle requests, in varying proportions, then walk both pointers through many wraps. In those mixes, order errors show up as a mismatch against the bench queue, and flag errors show up at the occupancy limits.

// File: rtl/sp_fifo_pkg.sv
package sp_fifo_pkg;

  // Strobes from control to datapath: at most one is high per cycle
  typedef struct packed {
    logic wrStrobe;  // perform a write into the slot under the write pointer
    logic rdStrobe;  // retire the slot under the read pointer
  } fifoStrobe_t;

endpackage

// File: rtl/sp_fifo_ptr.sv
module sp_fifo_ptr #(
  parameter int DEPTH  = 8,
  parameter int ADDR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              advance,
  output logic [ADDR_W-1:0] ptr
);

  localparam logic [ADDR_W-1:0] LAST = ADDR_W'(DEPTH - 1);

  logic [ADDR_W-1:0] ptrNext;

  always_comb begin
    ptrNext = ptr;
    if (advance) begin
      ptrNext = (ptr == LAST) ? '0 : ptr + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) ptr <= '0;
    else     ptr <= ptrNext;
  end

  // R8: a pointer never leaves the storage range, which keeps the wrap correct
  assert_ptr_in_range_R8: assert property (@(posedge clk) disable iff (rst)
    ptr <= LAST);

endmodule

// File: rtl/sp_fifo_ram.sv
module sp_fifo_ram #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 8,
  parameter int ADDR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);

  // No reset on the array: contents survive a controller reset (R9)
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
  end

  assign rdata = mem[addr];

endmodule

// File: rtl/sp_fifo_ctrl.sv
module sp_fifo_ctrl
  import sp_fifo_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        wrEn,
  input  logic        rdEn,
  output fifoStrobe_t strobe,
  output logic        full,
  output logic        empty
);

  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(DEPTH);

  logic [CNT_W-1:0] occCount;
  logic [CNT_W-1:0] occNext;

  assign empty = (occCount == '0);
  assign full  = (occCount == CNT_MAX);

  // A read request owns the shared port; writes need rdEn low
  always_comb begin
    strobe.rdStrobe = rdEn & ~empty;
    strobe.wrStrobe = wrEn & ~rdEn & ~full;
  end

  always_comb begin
    occNext = occCount;
    if (strobe.wrStrobe)      occNext = occCount + 1'b1;
    else if (strobe.rdStrobe) occNext = occCount - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) occCount <= '0;
    else     occCount <= occNext;
  end

  assert_reset_state_R1: assert property (@(posedge clk)
    rst |=> (empty && !full));

  assert_write_fills_R2: assert property (@(posedge clk) disable iff (rst)
    (wrEn && !rdEn && !full) |=> !empty);

  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (rst)
    (full && wrEn && !rdEn) |=> (full && $stable(occCount)));

  assert_no_underflow_R7: assert property (@(posedge clk) disable iff (rst)
    (empty && rdEn) |=> empty);

  assert_flags_exclusive_R8: assert property (@(posedge clk) disable iff (rst)
    !(full && empty));

  assert_count_bound_R8: assert property (@(posedge clk) disable iff (rst)
    occCount <= CNT_MAX);

  assert_one_access_R6: assert property (@(posedge clk) disable iff (rst)
    $countones({strobe.wrStrobe, strobe.rdStrobe}) <= 1);

endmodule

// File: rtl/sp_fifo_datapath.sv
module sp_fifo_datapath
  import sp_fifo_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 8,
  parameter int ADDR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  fifoStrobe_t       strobe,
  input  logic              rdEn,
  input  logic              occFull,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData
);

  localparam int WR_IDX = 0;
  localparam int RD_IDX = 1;

  logic [ADDR_W-1:0] ptrs [2];
  logic [1:0]        advance;
  logic [ADDR_W-1:0] memAddr;

  assign advance[WR_IDX] = strobe.wrStrobe;
  assign advance[RD_IDX] = strobe.rdStrobe;

  for (genvar gi = 0; gi < 2; gi++) begin : gPtr
    sp_fifo_ptr #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_ptr (
      .clk    (clk),
      .rst    (rst),
      .advance(advance[gi]),
      .ptr    (ptrs[gi])
    );
  end

  // Shared port: read request selects the read pointer, otherwise the write pointer
  assign memAddr = rdEn ? ptrs[RD_IDX] : ptrs[WR_IDX];

  sp_fifo_ram #(.DATA_W(DATA_W), .DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_ram (
    .clk  (clk),
    .we   (strobe.wrStrobe),
    .addr (memAddr),
    .wdata(wrData),
    .rdata(rdData)
  );

  // R4: once full, the write pointer has wrapped onto the oldest entry
  assert_full_ptrs_meet_R4: assert property (@(posedge clk) disable iff (rst)
    occFull |-> (ptrs[WR_IDX] == ptrs[RD_IDX]));

  // R6: a read cycle never moves the write pointer
  assert_read_blocks_write_R6: assert property (@(posedge clk) disable iff (rst)
    strobe.rdStrobe |=> $stable(ptrs[WR_IDX]));

  // R5: a granted read moves the read pointer on
  assert_read_advances_R5: assert property (@(posedge clk) disable iff (rst)
    strobe.rdStrobe |=> (ptrs[RD_IDX] != $past(ptrs[RD_IDX])));

endmodule

// File: rtl/sp_fifo_top.sv
module sp_fifo_top
  import sp_fifo_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  input  logic              rdEn,
  output logic [DATA_W-1:0] rdData,
  output logic              full,
  output logic              empty
);

  localparam int ADDR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W  = $clog2(DEPTH + 1);

  fifoStrobe_t strobe;

  sp_fifo_ctrl #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_ctrl (
    .clk   (clk),
    .rst   (rst),
    .wrEn  (wrEn),
    .rdEn  (rdEn),
    .strobe(strobe),
    .full  (full),
    .empty (empty)
  );

  sp_fifo_datapath #(.DATA_W(DATA_W), .DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_dp (
    .clk    (clk),
    .rst    (rst),
    .strobe (strobe),
    .rdEn   (rdEn),
    .occFull(full),
    .wrData (wrData),
    .rdData (rdData)
  );

endmodule

// File: tb/sp_fifo_top_bench.sv
`timescale 1ns/1ps
module sp_fifo_top_bench;

  localparam int DATA_W = 8;
  localparam int DEPTH  = 8;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              wrEn = 1'b0;
  logic              rdEn = 1'b0;
  logic [DATA_W-1:0] wrData = '0;
  logic [DATA_W-1:0] rdData;
  logic              full, empty;

  int checkCount = 0;
  int failCount  = 0;
  logic [DATA_W-1:0] modelQ [$];

  always #5 clk = ~clk;

  sp_fifo_top #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_sp_fifo_top (
    .clk(clk), .rst(rst), .wrEn(wrEn), .wrData(wrData),
    .rdEn(rdEn), .rdData(rdData), .full(full), .empty(empty)
  );

  function automatic logic expEmpty(int occ);
    return occ == 0;
  endfunction

  function automatic logic expFull(int occ);
    return occ == DEPTH;
  endfunction

  task automatic check(input bit ok, input string tag,
                       input logic [DATA_W-1:0] act, input logic [DATA_W-1:0] exp);
    checkCount++;
    if (!ok) begin
      failCount++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rst = 1'b1; wrEn = 1'b0; rdEn = 1'b0;
    @(negedge clk);
    rst = 1'b0;
    modelQ.delete();
  endtask

  // Drive one cycle's request, check outputs before the edge, update the model
  task automatic doCycle(input logic we, input logic re, input logic [DATA_W-1:0] d);
    @(negedge clk);
    wrEn = we; rdEn = re; wrData = d;
    #1;
    check(empty == expEmpty(modelQ.size()), "R8 empty", empty, expEmpty(modelQ.size()));
    check(full == expFull(modelQ.size()), "R8 full", full, expFull(modelQ.size()));
    if (re) begin
      if (modelQ.size() > 0) begin
        check(rdData == modelQ[0], "R5 read order", rdData, modelQ[0]);
        void'(modelQ.pop_front());
      end
      // read on empty (R7) and dropped write (R6): model unchanged
    end else if (modelQ.size() == DEPTH) begin
      check(rdData == modelQ[0], "R4 full shows oldest", rdData, modelQ[0]);
      // write while full (R3): model unchanged
    end else if (we) begin
      modelQ.push_back(d);  // R2
    end
  endtask

  initial begin : watchdog
    #(200000 * 10);
    failCount++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checkCount - failCount + 1, checkCount + 1);
    $finish;
  end

  initial begin : stim
    logic [DATA_W-1:0] firstWord;
    void'($urandom(32'd2024));

    // R1: reset state
    doReset();
    #1;
    check(empty == 1'b1, "R1 empty after reset", empty, 1'b1);
    check(full == 1'b0, "R1 full after reset", full, 1'b0);

    // R7: reads on empty
    doCycle(1'b0, 1'b1, 8'h00);
    doCycle(1'b0, 1'b1, 8'h00);
    @(negedge clk); #1;
    check(empty == 1'b1, "R7 empty holds", empty, 1'b1);

    // R2 then R3/R4: fill and keep writing while full
    for (int i = 0; i < DEPTH + 3; i++) doCycle(1'b1, 1'b0, DATA_W'(8'h10 + i));
    @(negedge clk); wrEn = 1'b0; rdEn = 1'b0; #1;
    check(full == 1'b1, "R3 full holds", full, 1'b1);
    check(rdData == 8'h10, "R4 oldest visible", rdData, 8'h10);

    // R6: read with concurrent write; dropped word must never appear
    doCycle(1'b1, 1'b1, 8'hAA);
    doCycle(1'b1, 1'b0, 8'h55);
    while (modelQ.size() > 0) doCycle(1'b0, 1'b1, 8'h00);
    doCycle(1'b0, 1'b1, 8'h00);

    // R9: memory survives reset
    doReset();
    for (int i = 0; i < DEPTH; i++) doCycle(1'b1, 1'b0, DATA_W'(8'hC0 + i));
    firstWord = 8'hC0;
    doReset();
    @(negedge clk); wrEn = 1'b0; rdEn = 1'b0; #1;
    check(rdData == firstWord, "R9 memory kept", rdData, firstWord);
    check(empty == 1'b1, "R1 empty after second reset", empty, 1'b1);

    // Random mixes with varying read/write bias
    for (int phase = 0; phase < 4; phase++) begin
      for (int n = 0; n < 600; n++) begin
        int r = int'($urandom_range(0, 99));
        logic we = (r < 30 + phase * 15);
        logic re = (int'($urandom_range(0, 99)) < 65 - phase * 15);
        doCycle(we, re, DATA_W'($urandom));
      end
    end
    while (modelQ.size() > 0) doCycle(1'b0, 1'b1, 8'h00);
    @(negedge clk); wrEn = 1'b0; rdEn = 1'b0; #1;
    check(empty == 1'b1, "R5 drained", empty, 1'b1);

    $display("%0d/%0d checks passed", checkCount - failCount, checkCount);
    $finish;
  end

endmodule